// File: doc/BRIEF.md
# Power and Command State Controller

This block is the control state machine that sits between a byte-wide command decoder and a phrase playback engine. Each accepted command byte carries an opcode in its upper nibble and an argument in its lower nibble. From these bytes the block tracks the power states: off, oscillator settling, output rise, idle, output fall and quick shutdown. It also tracks the command states: waiting for a phrase byte, playing, and a short processing gap after some commands. In each state it decides which opcodes are accepted. It drives two status lines: a command-ready flag and a not-busy flag. It also drives enables for the oscillator, the output ramp and the playback engine.

Long intervals are counted in millisecond ticks supplied from outside. Short intervals are counted in clock cycles. The block holds the 4-bit volume code, the 2-bit bank mode taken from the power-up byte, the loop flag and the current phrase number. Pop suppression itself and the gain arithmetic belong to neighbouring blocks.

Top module: `pwrctl_top`

## Requirements
- R1: After reset the block is powered off. In this state osc_en=0, cmd_rdy=1, not_busy=1, ramp_en=0, play_en=0, volume=0 (0 dB), bank_mode=0 and loop_on=0.
- R2: While powered off, only opcodes 0000 and 0001 (cmd_byte[7:4]) are acted on. Play (0100), stop (0110), volume (1010) and power-down bytes leave every output unchanged.
- R3: Opcode 0000 powers up quickly. From the next cycle, osc_en=1 and both status lines are low for STAB_MS ticks. After that both are high, and ramp_en stays low throughout.
- R4: Opcode 0001 powers up with a ramp. STAB_MS ticks of settling are followed by RAMP_MS ticks with ramp_en=1 and ramp_up=1. Both status lines stay low for the whole interval.
- R5: A power-up byte latches cmd_byte[1:0] into bank_mode. A power-up byte with cmd_byte[1:0]=11 is ignored, so the block stays off and bank_mode is kept.
- R6: Bytes received while the oscillator is settling or the output is ramping are ignored.
- R7: Reset from any state returns the block to the R1 state on the next clock.
- R8: Volume opcode 1010, accepted while idle or playing, loads cmd_byte[3:0] into volume. The value is kept through stop and power-down and is cleared only by reset.
- R9: In idle, opcode 0010 holds both status lines low for PD_CYC cycles and then powers off. Opcode 0011 holds ramp_en=1 with ramp_up=0 for RAMP_MS ticks and then powers off.
- R10: Power-down opcodes (0010, 0011) are ignored during playback.
- R11: Opcode 0100 in idle arms playback, and the next byte is taken whole as the phrase number. Playback then runs with play_en=1, not_busy=0 and cmd_rdy=1. A play_done pulse returns the block to idle.
- R12: Stop (0110) and volume are accepted in idle or play; loop-set (1000) and loop-clear (1001) only in play. Each is followed by GAP_CYC cycles with cmd_rdy=0 and not_busy=0, and bytes in that gap are ignored. Loop-set and loop-clear drive loop_on. Stop clears loop_on and ends in idle.
- R13: Opcodes with no function (for example 0101, 0111, 1111) change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ms_tick | input | 1 | One-cycle pulse each millisecond |
| cmd_valid | input | 1 | cmd_byte holds a new command byte |
| cmd_byte | input | 8 | Opcode in [7:4], argument in [3:0] |
| play_done | input | 1 | Playback engine reports end of phrase |
| cmd_rdy | output | 1 | High when command bytes are accepted |
| not_busy | output | 1 | Low while a phrase plays or power changes |
| osc_en | output | 1 | Oscillator enable |
| ramp_en | output | 1 | Output level ramp active |
| ramp_up | output | 1 | Ramp direction, 1 = rising |
| play_en | output | 1 | Playback engine enable |
| phrase | output | 8 | Latched phrase number |
| loop_on | output | 1 | Repeat playback flag |
| volume | output | 4 | Volume code, 0 = 0 dB, 15 = off |
| bank_mode | output | 2 | Latched bank mode |

## Verification
The hardest case to reach is a byte that lands inside a timed window: the settling interval, a ramp, or the post-command gap while a phrase is still playing. All of these must be ignored. The stimulus sends a volume byte right after a power-up byte, during a rising ramp, and in the gap after a volume change. The bench then confirms that the volume output kept its earlier value. A reset is also asserted in the middle of settling, and a power-down byte is sent while a phrase plays.

// File: rtl/pwrctl_pkg.sv
package pwrctl_pkg;

    typedef enum logic [3:0] {
        ST_OFF, ST_STAB, ST_RISE, ST_IDLE, ST_ARG,
        ST_PLAY, ST_GAP, ST_FALL, ST_QUICK
    } pstate_t;

    typedef enum logic [3:0] {
        A_NONE, A_UP_FAST, A_UP_SLOW, A_DN_FAST, A_DN_SLOW, A_ARM,
        A_PHRASE, A_STOP, A_LOOP_SET, A_LOOP_CLR, A_VOLUME
    } action_t;

    localparam logic [3:0] OP_UP_FAST  = 4'h0;
    localparam logic [3:0] OP_UP_SLOW  = 4'h1;
    localparam logic [3:0] OP_DN_FAST  = 4'h2;
    localparam logic [3:0] OP_DN_SLOW  = 4'h3;
    localparam logic [3:0] OP_PLAY     = 4'h4;
    localparam logic [3:0] OP_STOP     = 4'h6;
    localparam logic [3:0] OP_LOOP_SET = 4'h8;
    localparam logic [3:0] OP_LOOP_CLR = 4'h9;
    localparam logic [3:0] OP_VOLUME   = 4'hA;

    localparam logic [1:0] BANK_BAD = 2'b11;

    function automatic int unsigned max3(int unsigned a, int unsigned b, int unsigned c);
        int unsigned m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

endpackage

// File: rtl/pwrctl_decode.sv
module pwrctl_decode
    import pwrctl_pkg::*;
(
    input  pstate_t    st,
    input  logic       cmd_valid,
    input  logic [7:0] cmd_byte,
    output action_t    act
);
    logic [3:0] op;
    assign op = cmd_byte[7:4];

    always_comb begin
        act = A_NONE;
        if (cmd_valid) begin
            unique case (st)
                ST_OFF: begin
                    if (cmd_byte[1:0] != BANK_BAD) begin
                        if (op == OP_UP_FAST)      act = A_UP_FAST;
                        else if (op == OP_UP_SLOW) act = A_UP_SLOW;
                    end
                end
                ST_IDLE: begin
                    case (op)
                        OP_DN_FAST: act = A_DN_FAST;
                        OP_DN_SLOW: act = A_DN_SLOW;
                        OP_PLAY:    act = A_ARM;
                        OP_STOP:    act = A_STOP;
                        OP_VOLUME:  act = A_VOLUME;
                        default:    act = A_NONE;
                    endcase
                end
                ST_ARG: act = A_PHRASE;
                ST_PLAY: begin
                    case (op)
                        OP_STOP:     act = A_STOP;
                        OP_LOOP_SET: act = A_LOOP_SET;
                        OP_LOOP_CLR: act = A_LOOP_CLR;
                        OP_VOLUME:   act = A_VOLUME;
                        default:     act = A_NONE;
                    endcase
                end
                default: act = A_NONE;
            endcase
        end
    end
endmodule

// File: rtl/pwrctl_timer.sv
module pwrctl_timer #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             restart,
    input  logic             step,
    input  logic [CNT_W-1:0] limit,
    output logic             done
);
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || restart) cnt_q <= '0;
        else if (step)      cnt_q <= cnt_q + CNT_W'(1);
    end

    assign done = step && (cnt_q == limit - CNT_W'(1));
endmodule

// File: rtl/pwrctl_top.sv
module pwrctl_top
    import pwrctl_pkg::*;
#(
    parameter int STAB_MS = 2,
    parameter int RAMP_MS = 64,
    parameter int PD_CYC  = 8,
    parameter int GAP_CYC = 6
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       ms_tick,
    input  logic       cmd_valid,
    input  logic [7:0] cmd_byte,
    input  logic       play_done,
    output logic       cmd_rdy,
    output logic       not_busy,
    output logic       osc_en,
    output logic       ramp_en,
    output logic       ramp_up,
    output logic       play_en,
    output logic [7:0] phrase,
    output logic       loop_on,
    output logic [3:0] volume,
    output logic [1:0] bank_mode
);
    localparam int unsigned MAXL  = max3(STAB_MS, RAMP_MS, max3(PD_CYC, GAP_CYC, 1));
    localparam int          CNT_W = $clog2(MAXL + 1);

    pstate_t state_q, state_d, ret_q, ret_d;
    logic       slow_q, slow_d, loop_q, loop_d;
    logic [3:0] vol_q, vol_d;
    logic [1:0] bank_q, bank_d;
    logic [7:0] phr_q, phr_d;
    action_t    act;
    logic             step, done;
    logic [CNT_W-1:0] limit;

    pwrctl_decode u_dec (
        .st(state_q), .cmd_valid(cmd_valid), .cmd_byte(cmd_byte), .act(act)
    );

    // timed states: millisecond windows for power, cycle windows for commands
    always_comb begin
        step  = 1'b0;
        limit = CNT_W'(1);
        case (state_q)
            ST_STAB:          begin step = ms_tick; limit = CNT_W'(STAB_MS); end
            ST_RISE, ST_FALL: begin step = ms_tick; limit = CNT_W'(RAMP_MS); end
            ST_GAP:           begin step = 1'b1;    limit = CNT_W'(GAP_CYC); end
            ST_QUICK:         begin step = 1'b1;    limit = CNT_W'(PD_CYC);  end
            default:          begin step = 1'b0;    limit = CNT_W'(1);       end
        endcase
    end

    pwrctl_timer #(.CNT_W(CNT_W)) u_tmr (
        .clk(clk), .rst(rst), .restart(state_q != state_d),
        .step(step), .limit(limit), .done(done)
    );

    always_comb begin
        state_d = state_q;
        ret_d   = ret_q;
        slow_d  = slow_q;
        loop_d  = loop_q;
        vol_d   = vol_q;
        bank_d  = bank_q;
        phr_d   = phr_q;
        case (state_q)
            ST_OFF: begin
                if (act == A_UP_FAST || act == A_UP_SLOW) begin
                    state_d = ST_STAB;
                    slow_d  = (act == A_UP_SLOW);
                    bank_d  = cmd_byte[1:0];
                end
            end
            ST_STAB: if (done) state_d = slow_q ? ST_RISE : ST_IDLE;
            ST_RISE: if (done) state_d = ST_IDLE;
            ST_IDLE: begin
                case (act)
                    A_DN_FAST: state_d = ST_QUICK;
                    A_DN_SLOW: state_d = ST_FALL;
                    A_ARM:     state_d = ST_ARG;
                    A_STOP:    begin state_d = ST_GAP; ret_d = ST_IDLE; end
                    A_VOLUME:  begin state_d = ST_GAP; ret_d = ST_IDLE; vol_d = cmd_byte[3:0]; end
                    default:   state_d = ST_IDLE;
                endcase
            end
            ST_ARG: begin
                if (act == A_PHRASE) begin
                    state_d = ST_PLAY;
                    phr_d   = cmd_byte;
                end
            end
            ST_PLAY: begin
                if (play_done) begin
                    state_d = ST_IDLE;
                    loop_d  = 1'b0;
                end else begin
                    case (act)
                        A_STOP:     begin state_d = ST_GAP; ret_d = ST_IDLE; loop_d = 1'b0; end
                        A_LOOP_SET: begin state_d = ST_GAP; ret_d = ST_PLAY; loop_d = 1'b1; end
                        A_LOOP_CLR: begin state_d = ST_GAP; ret_d = ST_PLAY; loop_d = 1'b0; end
                        A_VOLUME:   begin state_d = ST_GAP; ret_d = ST_PLAY; vol_d = cmd_byte[3:0]; end
                        default:    state_d = ST_PLAY;
                    endcase
                end
            end
            ST_GAP: begin
                // a phrase that ends inside the gap must not resume playing
                if (play_done && ret_q == ST_PLAY) begin
                    ret_d  = ST_IDLE;
                    loop_d = 1'b0;
                end
                if (done) state_d = (play_done && ret_q == ST_PLAY) ? ST_IDLE : ret_q;
            end
            ST_FALL:  if (done) state_d = ST_OFF;
            ST_QUICK: if (done) state_d = ST_OFF;
            default:  state_d = ST_OFF;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_OFF;
            ret_q   <= ST_IDLE;
            slow_q  <= 1'b0;
            loop_q  <= 1'b0;
            vol_q   <= 4'd0;
            bank_q  <= 2'd0;
            phr_q   <= 8'd0;
        end else begin
            state_q <= state_d;
            ret_q   <= ret_d;
            slow_q  <= slow_d;
            loop_q  <= loop_d;
            vol_q   <= vol_d;
            bank_q  <= bank_d;
            phr_q   <= phr_d;
        end
    end

    assign cmd_rdy   = (state_q == ST_OFF) || (state_q == ST_IDLE) ||
                       (state_q == ST_ARG) || (state_q == ST_PLAY);
    assign not_busy  = (state_q == ST_OFF) || (state_q == ST_IDLE) || (state_q == ST_ARG);
    assign osc_en    = (state_q != ST_OFF);
    assign ramp_en   = (state_q == ST_RISE) || (state_q == ST_FALL);
    assign ramp_up   = (state_q == ST_RISE);
    assign play_en   = (state_q == ST_PLAY) || (state_q == ST_GAP && ret_q == ST_PLAY);
    assign phrase    = phr_q;
    assign loop_on   = loop_q;
    assign volume    = vol_q;
    assign bank_mode = bank_q;
endmodule

// File: rtl/pwrctl_chk.sv
module pwrctl_chk (
    input logic       clk,
    input logic       rst,
    input logic       cmd_valid,
    input logic       cmd_rdy,
    input logic       not_busy,
    input logic       osc_en,
    input logic       ramp_en,
    input logic       play_en,
    input logic [3:0] volume,
    input logic [1:0] bank_mode
);
    p_off_status_r1: assert property (@(posedge clk) disable iff (rst)
        !osc_en |-> (cmd_rdy && not_busy));

    p_ramp_quiet_r4: assert property (@(posedge clk) disable iff (rst)
        ramp_en |-> (!cmd_rdy && !not_busy));

    p_bank_legal_r5: assert property (@(posedge clk) disable iff (rst)
        bank_mode != 2'b11);

    p_vol_hold_r8: assert property (@(posedge clk) disable iff (rst)
        !cmd_valid |=> $stable(volume));

    p_play_keeps_power_r10: assert property (@(posedge clk) disable iff (rst)
        play_en |=> osc_en);
endmodule

bind pwrctl_top pwrctl_chk u_chk (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_rdy(cmd_rdy),
    .not_busy(not_busy), .osc_en(osc_en), .ramp_en(ramp_en),
    .play_en(play_en), .volume(volume), .bank_mode(bank_mode)
);

// File: tb/tb_pwrctl_top.sv
module tb_pwrctl_top;
    localparam int STAB = 2, RAMP = 64, PDC = 8, GAPC = 6;

    logic clk = 1'b0, rst = 1'b1, ms_tick = 1'b0, cmd_valid = 1'b0, play_done = 1'b0;
    logic [7:0] cmd_byte = 8'h00;
    logic cmd_rdy, not_busy, osc_en, ramp_en, ramp_up, play_en, loop_on;
    logic [7:0] phrase;
    logic [3:0] volume;
    logic [1:0] bank_mode;

    int total = 0, bad = 0, cyc = 0, tdiv = 0;

    pwrctl_top #(.STAB_MS(STAB), .RAMP_MS(RAMP), .PD_CYC(PDC), .GAP_CYC(GAPC)) dut (
        .clk(clk), .rst(rst), .ms_tick(ms_tick), .cmd_valid(cmd_valid),
        .cmd_byte(cmd_byte), .play_done(play_done), .cmd_rdy(cmd_rdy),
        .not_busy(not_busy), .osc_en(osc_en), .ramp_en(ramp_en), .ramp_up(ramp_up),
        .play_en(play_en), .phrase(phrase), .loop_on(loop_on), .volume(volume),
        .bank_mode(bank_mode)
    );

    always #5 clk = ~clk;

    // reference model: 0 off,1 settle,2 rise,3 idle,4 arg,5 play,6 gap,7 fall,8 quick
    int m = 0, rem = 0, back = 3, mslow = 0, mvol = 0, mbank = 0, mloop = 0, mphr = 0;

    always @(posedge clk) begin
        int op;
        op = int'(cmd_byte[7:4]);
        if (rst) begin
            m = 0; mvol = 0; mbank = 0; mloop = 0; mphr = 0; mslow = 0; back = 3;
        end else begin
            case (m)
                0: if (cmd_valid && op <= 1 && cmd_byte[1:0] != 2'b11) begin
                       mbank = int'(cmd_byte[1:0]); mslow = op; m = 1; rem = STAB;
                   end
                1: if (ms_tick) begin
                       if (rem == 1) begin m = mslow ? 2 : 3; rem = RAMP; end else rem--;
                   end
                2: if (ms_tick) begin if (rem == 1) m = 3; else rem--; end
                3: if (cmd_valid) begin
                       if (op == 2) begin m = 8; rem = PDC; end
                       else if (op == 3) begin m = 7; rem = RAMP; end
                       else if (op == 4) m = 4;
                       else if (op == 6) begin m = 6; rem = GAPC; back = 3; end
                       else if (op == 10) begin mvol = int'(cmd_byte[3:0]); m = 6; rem = GAPC; back = 3; end
                   end
                4: if (cmd_valid) begin mphr = int'(cmd_byte); m = 5; end
                5: if (play_done) begin m = 3; mloop = 0; end
                   else if (cmd_valid) begin
                       if (op == 6) begin mloop = 0; m = 6; rem = GAPC; back = 3; end
                       else if (op == 8) begin mloop = 1; m = 6; rem = GAPC; back = 5; end
                       else if (op == 9) begin mloop = 0; m = 6; rem = GAPC; back = 5; end
                       else if (op == 10) begin mvol = int'(cmd_byte[3:0]); m = 6; rem = GAPC; back = 5; end
                   end
                6: begin
                       if (play_done && back == 5) begin back = 3; mloop = 0; end
                       if (rem == 1) m = back; else rem--;
                   end
                7: if (ms_tick) begin if (rem == 1) m = 0; else rem--; end
                8: if (rem == 1) m = 0; else rem--;
                default: m = 0;
            endcase
        end
    end

    task automatic cmp(string tag, int act, int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d t=%0t", tag, act, exp, $time);
        end
    endtask

    // per-cycle comparison against the model, away from the active edge
    always @(negedge clk) begin
        cyc++;
        tdiv = (tdiv + 1) % 4;
        ms_tick <= (tdiv == 0);
        if (!rst) begin
            cmp("R12 cmd_rdy", int'(cmd_rdy), int'(m == 0 || m == 3 || m == 4 || m == 5));
            cmp("R11 not_busy", int'(not_busy), int'(m == 0 || m == 3 || m == 4));
            cmp("R3 osc_en", int'(osc_en), int'(m != 0));
            cmp("R4 ramp_en", int'(ramp_en), int'(m == 2 || m == 7));
            cmp("R9 ramp_up", int'(ramp_up), int'(m == 2));
            cmp("R11 play_en", int'(play_en), int'(m == 5 || (m == 6 && back == 5)));
            cmp("R11 phrase", int'(phrase), mphr);
            cmp("R12 loop_on", int'(loop_on), mloop);
            cmp("R8 volume", int'(volume), mvol);
            cmp("R5 bank_mode", int'(bank_mode), mbank);
        end
        if (cyc > 20000) begin
            bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic send(logic [7:0] b);
        @(negedge clk); cmd_valid = 1'b1; cmd_byte = b;
        @(negedge clk); cmd_valid = 1'b0; cmd_byte = 8'h00;
    endtask

    task automatic wait_ready();
        for (int i = 0; i < 2000 && !(cmd_rdy && not_busy); i++) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        cmp("R1 osc_en", int'(osc_en), 0);
        cmp("R1 ready", int'(cmd_rdy && not_busy), 1);
        cmp("R1 volume", int'(volume), 0);

        send(8'hA5); send(8'h60); send(8'h40); send(8'h20);
        cmp("R2 volume", int'(volume), 0);
        cmp("R2 osc_en", int'(osc_en), 0);
        send(8'h03);
        cmp("R5 bad bank ignored", int'(osc_en), 0);

        send(8'h02);
        cmp("R3 osc_en", int'(osc_en), 1);
        cmp("R3 cmd_rdy", int'(cmd_rdy), 0);
        send(8'hA7);
        wait_ready();
        cmp("R6 volume", int'(volume), 0);
        cmp("R5 bank_mode", int'(bank_mode), 2);
        cmp("R3 ramp_en", int'(ramp_en), 0);

        send(8'hA3);
        cmp("R12 gap cmd_rdy", int'(cmd_rdy), 0);
        send(8'hA7);
        wait_ready();
        cmp("R8 volume", int'(volume), 3);
        cmp("R12 gap ignored", int'(volume), 3);

        send(8'h50); send(8'h70); send(8'hF0);
        cmp("R13 idle kept", int'(cmd_rdy && not_busy && osc_en && !play_en), 1);

        send(8'h40); send(8'h2B);
        cmp("R11 play_en", int'(play_en), 1);
        cmp("R11 phrase", int'(phrase), 8'h2B);
        send(8'h20);
        cmp("R10 still playing", int'(play_en && osc_en), 1);
        send(8'h80);
        cmp("R12 loop set", int'(loop_on), 1);
        repeat (GAPC + 1) @(negedge clk);
        send(8'hA9);
        repeat (GAPC + 1) @(negedge clk);
        send(8'h60);
        cmp("R12 stop clears loop", int'(loop_on), 0);
        wait_ready();
        cmp("R12 stop to idle", int'(play_en), 0);
        cmp("R8 kept through stop", int'(volume), 9);

        send(8'h40); send(8'h05);
        @(negedge clk); play_done = 1'b1; @(negedge clk); play_done = 1'b0;
        cmp("R11 done to idle", int'(play_en == 0 && not_busy == 1), 1);

        send(8'h20);
        cmp("R9 quick busy", int'(not_busy), 0);
        wait_ready();
        cmp("R9 quick off", int'(osc_en), 0);
        cmp("R8 kept through power-down", int'(volume), 9);

        send(8'h11);
        for (int i = 0; i < 200 && !ramp_en; i++) @(negedge clk);
        cmp("R4 rising", int'(ramp_en && ramp_up), 1);
        send(8'hA0);
        wait_ready();
        cmp("R6 ramp ignored", int'(volume), 9);
        cmp("R5 bank_mode", int'(bank_mode), 1);
        send(8'h30);
        cmp("R9 falling", int'(ramp_en && !ramp_up), 1);
        wait_ready();
        cmp("R9 slow off", int'(osc_en), 0);

        send(8'h00);
        @(negedge clk); rst = 1'b1; @(negedge clk); rst = 1'b0;
        cmp("R7 reset off", int'(osc_en), 0);
        cmp("R7 volume", int'(volume), 0);

        repeat (4) @(negedge clk);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule